// File: doc/BRIEF.md
# Secure Memory Region Lock Gate

This block sits between a byte-wide memory port and a RAM model and guards a segment at the top of RAM. Software sets the block up through a small byte-wide configuration interface that holds two registers. A control register carries open, close, lock and global-enable bits. An extended register carries a region-enable bit and a two-bit size code. While protection is active, an access from outside the privileged mode that lands in the segment is refused. A refused read returns 0xFF and a refused write is discarded. Privileged accesses reach RAM unless the close bit is set.

Segment sizes are counted in units of `2**UNIT_W` bytes, so the RAM holds `RAM_UNITS` units. Three of the size codes pick fixed sizes. The fourth code takes the size from the `ext_units_i` input. Once the lock bit is set, it clears the open bit and keeps it clear. It also freezes the size code, the region-enable bit and the global-enable bit. Only a reset releases the lock.

Top module: `secmem_gate`

## Requirements
- R1: After reset, both registers read 0x00 and no access is refused. Register address 0 is the control register, with open at bit 6, close at bit 5, lock at bit 4 and global enable at bit 3. Register address 1 is the extended register, with region enable at bit 0 and the size code at bits 2:1. All other bits read 0.
- R2: While lock is clear, the open bit follows each write to the control register and reads back as written.
- R3: A control write with bit 4 set leaves lock at 1 and open at 0, even if the same write sets bit 6.
- R4: While lock is set, a write cannot clear lock or set open. Reset clears lock, and after that open is writable again.
- R5: Size code 0 gives 1 unit, code 1 gives 2 units, code 2 gives 8 units, and code 3 gives `ext_units_i` units.
- R6: The segment starts at byte (RAM_UNITS minus the size) times the unit size and runs to the top of RAM. The byte just below the start is plain read/write memory.
- R7: Protection is active when region enable and global enable are both 1. With protection active and open clear, a non-privileged access inside the segment reads 0xFF and its write leaves RAM unchanged.
- R8: While lock is set, writes do not change the size code, region enable or global enable. The close bit stays writable.
- R9: A privileged access inside an active segment reaches RAM when close is 0. It is refused when close is 1 and open is 0.
- R10: While open is 1, non-privileged accesses inside an active segment reach RAM.
- R11: A memory access is judged against the register state from before any configuration write in the same cycle. Read data and `mem_rvalid_o` appear one cycle after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 1 | Register select: 0 is control, 1 is extended |
| cfg_wdata_i | input | 8 | Configuration write data |
| cfg_rdata_o | output | 8 | Combinational read of the selected register |
| ext_units_i | input | EXT_W | Segment size in units, used for size code 3 |
| mem_req_i | input | 1 | Memory access request |
| mem_we_i | input | 1 | 1 for a write, 0 for a read |
| mem_priv_i | input | 1 | Access comes from the privileged mode |
| mem_addr_i | input | ADDR_W | Byte address |
| mem_wdata_i | input | 8 | Write data |
| mem_rdata_o | output | 8 | Read data, one cycle after the request |
| mem_rvalid_o | output | 1 | Read data valid |

## Verification
A configuration write and a memory access can fall in the same cycle. The write can change the protection that the access is judged against. The bench provokes this by driving a control write that sets open together with a non-privileged read of the top byte of an active segment, and then repeating the read on its own. The first read must return 0xFF, because it is judged against the old state. The second must return the stored byte. The lock sequence, the four size codes and a reset taken in the middle of the run are checked through the scoreboard against values computed in the bench.

// File: rtl/secmem_pkg.sv
package secmem_pkg;
  localparam int CTL_OPEN  = 6;
  localparam int CTL_CLOSE = 5;
  localparam int CTL_LOCK  = 4;
  localparam int CTL_GEN   = 3;
  localparam int EXT_REN   = 0;
  localparam int EXT_SZ_LO = 1;

  typedef enum logic [1:0] {
    SZ_1   = 2'd0,
    SZ_2   = 2'd1,
    SZ_8   = 2'd2,
    SZ_EXT = 2'd3
  } seg_size_e;

  typedef struct packed {
    logic      open;
    logic      close;
    logic      lock;
    logic      gen;
    logic      ren;
    seg_size_e size;
  } ctl_t;
endpackage

// File: rtl/secmem_regs.sv
module secmem_regs
  import secmem_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_i,
  input  logic       addr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  output ctl_t       ctl_o
);
  ctl_t ctl_q;
  logic lock_next;

  assign lock_next = ctl_q.lock | wdata_i[CTL_LOCK];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q <= '0;
    end else if (we_i) begin
      if (!addr_i) begin
        ctl_q.lock  <= lock_next;
        ctl_q.open  <= wdata_i[CTL_OPEN] & ~lock_next;
        ctl_q.close <= wdata_i[CTL_CLOSE];
        if (!ctl_q.lock) ctl_q.gen <= wdata_i[CTL_GEN];
      end else if (!ctl_q.lock) begin
        ctl_q.ren  <= wdata_i[EXT_REN];
        ctl_q.size <= seg_size_e'(wdata_i[EXT_SZ_LO+:2]);
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (!addr_i) begin
      rdata_o[CTL_OPEN]  = ctl_q.open;
      rdata_o[CTL_CLOSE] = ctl_q.close;
      rdata_o[CTL_LOCK]  = ctl_q.lock;
      rdata_o[CTL_GEN]   = ctl_q.gen;
    end else begin
      rdata_o[EXT_REN]          = ctl_q.ren;
      rdata_o[EXT_SZ_LO+:2]     = ctl_q.size;
    end
  end

  assign ctl_o = ctl_q;

  assert_lock_clears_open_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_q.lock |-> !ctl_q.open);
  assert_lock_sticky_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_q.lock |=> ctl_q.lock);
  assert_fields_frozen_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_q.lock |=> ($stable(ctl_q.size) && $stable(ctl_q.ren) && $stable(ctl_q.gen)));
endmodule

// File: rtl/secmem_filter.sv
module secmem_filter
  import secmem_pkg::*;
#(
  parameter int UNIT_W    = 4,
  parameter int RAM_UNITS = 128,
  parameter int EXT_W     = 8,
  parameter int ADDR_W    = 11
) (
  input  ctl_t              ctl_i,
  input  logic [EXT_W-1:0]  ext_units_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              priv_i,
  output logic              pass_o
);
  logic [31:0] seg_units;
  logic [31:0] base_units;
  logic [31:0] base_byte;
  logic        in_seg;
  logic        active;

  always_comb begin
    unique case (ctl_i.size)
      SZ_1:    seg_units = 32'd1;
      SZ_2:    seg_units = 32'd2;
      SZ_8:    seg_units = 32'd8;
      default: seg_units = 32'(ext_units_i);
    endcase
  end

  // a segment wider than RAM covers all of it
  assign base_units = (seg_units >= 32'(RAM_UNITS)) ? 32'd0 : 32'(RAM_UNITS) - seg_units;
  assign base_byte  = base_units << UNIT_W;
  assign in_seg     = (seg_units != 32'd0) && (32'(addr_i) >= base_byte);
  assign active     = ctl_i.ren & ctl_i.gen;
  assign pass_o     = !(active && in_seg) || ctl_i.open || (priv_i && !ctl_i.close);
endmodule

// File: rtl/secmem_ram.sv
module secmem_ram #(
  parameter int ADDR_W = 11
) (
  input  logic              clk_i,
  input  logic              en_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;
  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (en_i) begin
      if (we_i) mem_q[addr_i] <= wdata_i;
      else      rdata_o       <= mem_q[addr_i];
    end
  end
endmodule

// File: rtl/secmem_gate.sv
module secmem_gate
  import secmem_pkg::*;
#(
  parameter int UNIT_W    = 4,
  parameter int RAM_UNITS = 128,
  parameter int EXT_W     = 8,
  localparam int ADDR_W   = $clog2(RAM_UNITS) + UNIT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic              cfg_addr_i,
  input  logic [7:0]        cfg_wdata_i,
  output logic [7:0]        cfg_rdata_o,
  input  logic [EXT_W-1:0]  ext_units_i,
  input  logic              mem_req_i,
  input  logic              mem_we_i,
  input  logic              mem_priv_i,
  input  logic [ADDR_W-1:0] mem_addr_i,
  input  logic [7:0]        mem_wdata_i,
  output logic [7:0]        mem_rdata_o,
  output logic              mem_rvalid_o
);
  ctl_t       ctl;
  logic       pass;
  logic [7:0] ram_rdata;
  logic       blk_q;
  logic       rvalid_q;

  secmem_regs u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .addr_i  (cfg_addr_i),
    .wdata_i (cfg_wdata_i),
    .rdata_o (cfg_rdata_o),
    .ctl_o   (ctl)
  );

  secmem_filter #(
    .UNIT_W    (UNIT_W),
    .RAM_UNITS (RAM_UNITS),
    .EXT_W     (EXT_W),
    .ADDR_W    (ADDR_W)
  ) u_filter (
    .ctl_i       (ctl),
    .ext_units_i (ext_units_i),
    .addr_i      (mem_addr_i),
    .priv_i      (mem_priv_i),
    .pass_o      (pass)
  );

  secmem_ram #(.ADDR_W(ADDR_W)) u_ram (
    .clk_i   (clk_i),
    .en_i    (mem_req_i & pass),
    .we_i    (mem_we_i),
    .addr_i  (mem_addr_i),
    .wdata_i (mem_wdata_i),
    .rdata_o (ram_rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      blk_q    <= 1'b0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= mem_req_i & ~mem_we_i;
      if (mem_req_i && !mem_we_i) blk_q <= ~pass;
    end
  end

  assign mem_rdata_o  = blk_q ? 8'hFF : ram_rdata;
  assign mem_rvalid_o = rvalid_q;

  assert_blocked_read_ff_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_i && !mem_we_i && !pass) |=> (mem_rdata_o == 8'hFF));
  assert_read_latency_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_i && !mem_we_i) |=> mem_rvalid_o);
  assert_idle_quiet_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_req_i |=> !mem_rvalid_o);
endmodule

// File: tb/secmem_gate_tb.sv
`timescale 1ns/1ps
module secmem_gate_tb;
  localparam int UNIT_W = 4, RAM_UNITS = 128, EXT_W = 8;
  localparam int ADDR_W = $clog2(RAM_UNITS) + UNIT_W;
  localparam int UB = 1 << UNIT_W;

  logic clk = 0, rst_ni = 0;
  logic cfg_we = 0, cfg_addr = 0;
  logic [7:0] cfg_wdata = 0, cfg_rdata;
  logic [EXT_W-1:0] ext_units = 8'd16;
  logic mem_req = 0, mem_we = 0, mem_priv = 0;
  logic [ADDR_W-1:0] mem_addr = 0;
  logic [7:0] mem_wdata = 0, mem_rdata;
  logic mem_rvalid;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  secmem_gate #(.UNIT_W(UNIT_W), .RAM_UNITS(RAM_UNITS), .EXT_W(EXT_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr),
    .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(cfg_rdata), .ext_units_i(ext_units),
    .mem_req_i(mem_req), .mem_we_i(mem_we), .mem_priv_i(mem_priv),
    .mem_addr_i(mem_addr), .mem_wdata_i(mem_wdata), .mem_rdata_o(mem_rdata),
    .mem_rvalid_o(mem_rvalid));

  // monitor: pop scoreboard on every returned read
  always @(negedge clk) begin
    if (mem_rvalid) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL unexpected read data %02h", mem_rdata);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (mem_rdata !== e) begin
          fails++;
          $display("FAIL %s: read %02h expected %02h", t, mem_rdata, e);
        end
      end
    end
  end

  task automatic cfg_wr(input logic a, input logic [7:0] d);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic cfg_chk(input logic a, input logic [7:0] e, input string t);
    cfg_addr = a;
    #1;
    checks++;
    if (cfg_rdata !== e) begin
      fails++;
      $display("FAIL %s: reg%0d read %02h expected %02h", t, a, cfg_rdata, e);
    end
  endtask

  task automatic mem_wr(input logic p, input int a, input logic [7:0] d);
    mem_req = 1; mem_we = 1; mem_priv = p; mem_addr = ADDR_W'(a); mem_wdata = d;
    @(negedge clk);
    mem_req = 0; mem_we = 0;
  endtask

  task automatic mem_rd(input logic p, input int a, input logic [7:0] e, input string t);
    mem_req = 1; mem_we = 0; mem_priv = p; mem_addr = ADDR_W'(a);
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    mem_req = 0;
  endtask

  // R11: config write and memory read in the same cycle
  task automatic collide_rd(input logic [7:0] ctl, input int a, input logic [7:0] e);
    cfg_we = 1; cfg_addr = 0; cfg_wdata = ctl;
    mem_req = 1; mem_we = 0; mem_priv = 0; mem_addr = ADDR_W'(a);
    exp_q.push_back(e); tag_q.push_back("R11 collision");
    @(negedge clk);
    cfg_we = 0; mem_req = 0;
  endtask

  task automatic drain();
    @(negedge clk); @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    // R1 reset state
    cfg_chk(0, 8'h00, "R1 ctrl reset");
    cfg_chk(1, 8'h00, "R1 ext reset");
    mem_wr(0, 2047, 8'h5A);
    mem_rd(0, 2047, 8'h5A, "R1 inactive top byte");
    // R2 open toggles before lock
    cfg_wr(0, 8'h40); cfg_chk(0, 8'h40, "R2 open set");
    cfg_wr(0, 8'h00); cfg_chk(0, 8'h00, "R2 open clear");
    // R5/R6/R7/R9 over all size codes
    for (int c = 0; c < 4; c++) begin
      int u, b;
      u = (c == 0) ? 1 : (c == 1) ? 2 : (c == 2) ? 8 : 16;
      b = (RAM_UNITS - u) * UB;
      cfg_wr(1, 8'h00); cfg_wr(0, 8'h00);
      mem_wr(0, b - 1, 8'h11);
      mem_wr(0, b, 8'h22);
      cfg_wr(0, 8'h28);
      cfg_wr(1, 8'(1 | (c << 1)));
      cfg_chk(1, 8'(1 | (c << 1)), "R5 ext readback");
      mem_rd(0, b - 1, 8'h11, "R6 below base");
      mem_wr(0, b - 1, 8'h33);
      mem_rd(0, b - 1, 8'h33, "R6 below base rw");
      mem_rd(0, b, 8'hFF, "R5 R7 base blocked");
      mem_wr(0, b, 8'h77);
      mem_rd(0, b, 8'hFF, "R7 blocked after write");
      mem_rd(1, b, 8'hFF, "R9 priv closed");
      cfg_wr(0, 8'h08);
      mem_rd(1, b, 8'h22, "R7 R9 write dropped, priv open");
      mem_wr(1, b, 8'h44);
      mem_rd(1, b, 8'h44, "R9 priv write");
    end
    // R10 open grants non-priv access
    cfg_wr(1, 8'h01);
    cfg_wr(0, 8'h48);
    mem_rd(0, 2047, 8'h5A, "R10 open");
    cfg_wr(0, 8'h08);
    mem_rd(0, 2047, 8'hFF, "R10 open cleared");
    // R11 collision uses old state, next read uses new
    collide_rd(8'h48, 2047, 8'hFF);
    mem_rd(0, 2047, 8'h5A, "R11 after write");
    // R3/R4/R8 lock
    cfg_chk(0, 8'h48, "R2 open before lock");
    cfg_wr(0, 8'h58); cfg_chk(0, 8'h18, "R3 lock clears open");
    cfg_wr(0, 8'h48); cfg_chk(0, 8'h18, "R4 open not settable");
    cfg_wr(0, 8'h00); cfg_chk(0, 8'h18, "R4 R8 lock and gen held");
    cfg_wr(0, 8'h20); cfg_chk(0, 8'h38, "R8 close writable");
    cfg_wr(1, 8'h06); cfg_chk(1, 8'h01, "R8 ext frozen");
    mem_rd(0, 2047, 8'hFF, "R4 locked blocks");
    drain();
    // R4 reset releases lock
    rst_ni = 0;
    @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    cfg_chk(0, 8'h00, "R4 ctrl after reset");
    cfg_chk(1, 8'h00, "R4 ext after reset");
    cfg_wr(0, 8'h40); cfg_chk(0, 8'h40, "R4 open writable again");
    mem_rd(0, 2047, 8'h5A, "R1 inactive after reset");
    drain();
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R11 missing %0d reads, expected 0", exp_q.size());
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule